// File: doc/BRIEF.md
# Disk Controller Command Sequencer

This block is the control and status core of a small multi-drive disk controller, seen from a host register port. The host writes three registers: a control word that carries the function code, the start bit, the interrupt enable and the target unit; a sector address; and a memory buffer address. The block then runs one of five functions: RESET, SEEK, HOME, READ or WRITE. It keeps a ready flag and a write-lock violation flag for each drive unit, and it raises a level interrupt request whenever the interrupt enable and the done flag are both set.

Data movement is out of scope. A transfer stub sees `xfer_req_o` and answers with a one-cycle `sector_done_i`. The stub may report a non-existent memory fault on `nxm_i` in the same cycle. SEEK and HOME finish after a fixed, short delay instead of at once, so that software which clears its interrupt flag right after issuing the command still sees the later interrupt. Every sector that starts moves the sector address forward when it ends, even if the sector failed.

Top module: `disk_seq`

## Requirements
- R1: A control write (`wr_sel_i`=0) with the start bit (bit 0) set and function RESET (bits 3:1 = 0) is accepted in any state, including mid-transfer. On the next cycle `done_o`=1, `busy_o`=0, `xfer_req_o`=0 and all controller errors (`err_*_o`) are 0. IE takes the written bit 6 and is not forced to 0.
- R2: `irq_o` is high whenever `ie_o` and `done_o` are both high, and low otherwise. Reset leaves `done_o`=1, `ie_o`=0 and `irq_o`=0.
- R3: A control write with the start bit clear loads IE (bit 6), function (bits 3:1) and unit (bits from 8 up) and starts nothing. While `busy_o`=1, every control write other than RESET with start is ignored. Function codes are 0 RESET, 1 WRITE, 2 READ, 3 SEEK, 4 HOME, and the other codes do nothing.
- R4: SEEK or HOME with start drops `done_o` on the next cycle and sets it again exactly `SEEK_DLY` cycles after the accepting edge.
- R5: A SEEK/HOME wait never lasts 25 cycles or more. `SEEK_DLY` defaults to 10.
- R6: READ or WRITE on a ready, unlocked unit holds `xfer_req_o` high until `sector_done_i`. On the next cycle `done_o`=1 and `da_o` has moved forward by one. `xfer_write_o` is high for WRITE.
- R7: When `nxm_i` is high with `sector_done_i`, `err_nxm_o` is set and `da_o` still moves forward by one.
- R8: A sector that ends with `da_o` = `N_SECT`-1 wraps `da_o` to 0 and sets `err_ovf_o`.
- R9: If `seek_fail_i` is high on the cycle a SEEK finishes, that unit's bit of `drv_rdy_o` goes to 0. A SEEK, READ or WRITE to a unit that is not ready is refused: `err_nrdy_o`=1, `done_o` stays 1, no transfer starts and `da_o` does not change.
- R10: HOME runs on a unit that is not ready and sets its `drv_rdy_o` bit back to 1 when it finishes.
- R11: Each unit keeps its own ready and write-lock violation flags. An event on one unit leaves the flags of the other units unchanged.
- R12: WRITE to a unit whose `wlock_i` bit is set starts no transfer and leaves `da_o` unchanged. It sets `err_wlv_o` and that unit's `drv_wlv_o` bit, which stays set until a RESET function.
- R13: A buffer address write (`wr_sel_i`=2) loads `ba_o` with the low `BA_W` (22) bits of the data. The higher bits are dropped and raise no error. A sector address write (`wr_sel_i`=1) is applied only while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host register write strobe |
| wr_sel_i | input | 2 | Register select: 0 control, 1 sector address, 2 buffer address |
| wr_data_i | input | 32 | Host write data |
| wlock_i | input | N_UNITS | Write-lock setting per unit |
| seek_fail_i | input | 1 | Seek error reported at SEEK completion |
| sector_done_i | input | 1 | Transfer stub: sector finished |
| nxm_i | input | 1 | Transfer stub: non-existent memory fault, valid with sector_done_i |
| irq_o | output | 1 | Interrupt request |
| done_o | output | 1 | Controller done |
| ie_o | output | 1 | Interrupt enable |
| busy_o | output | 1 | Function in progress |
| func_o | output | 3 | Latched function code |
| unit_o | output | UW | Latched unit number |
| err_nxm_o | output | 1 | Memory fault on last sector |
| err_ovf_o | output | 1 | Sector address wrapped past last sector |
| err_wlv_o | output | 1 | Write refused by write lock |
| err_nrdy_o | output | 1 | Command refused, unit not ready |
| da_o | output | DA_W | Sector address |
| ba_o | output | BA_W | Buffer address |
| xfer_req_o | output | 1 | Sector transfer requested |
| xfer_write_o | output | 1 | Transfer direction is write |
| drv_rdy_o | output | N_UNITS | Per-unit ready |
| drv_wlv_o | output | N_UNITS | Per-unit write-lock violation |

## Verification
The hardest state to reach from the ports is a unit left not ready. `seek_fail_i` counts only on the one cycle a SEEK wait ends, so the bench holds it high across the whole wait and then checks the other units to show they stayed ready. A second hard case is a RESET that lands while a transfer is outstanding. The bench issues it with the stub still silent, so the abort path can be told apart from a normal sector end.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
  typedef enum logic [2:0] {
    FN_RESET = 3'd0,
    FN_WRITE = 3'd1,
    FN_READ  = 3'd2,
    FN_SEEK  = 3'd3,
    FN_HOME  = 3'd4
  } func_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_XFER
  } state_e;

  localparam logic [1:0] SEL_CSR = 2'd0;
  localparam logic [1:0] SEL_DA  = 2'd1;
  localparam logic [1:0] SEL_BA  = 2'd2;

  localparam int CSR_GO   = 0;
  localparam int CSR_FN   = 1;
  localparam int CSR_IE   = 6;
  localparam int CSR_UNIT = 8;
endpackage

// File: rtl/dsq_timer.sv
module dsq_timer #(
  parameter int DLY = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  output logic fin_o
);
  localparam int TW = (DLY > 1) ? $clog2(DLY) : 1;
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (start_i) cnt_q <= TW'(DLY - 1);
    else if (run_i && cnt_q != '0) cnt_q <= cnt_q - TW'(1);
  end

  assign fin_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/dsq_addr.sv
module dsq_addr #(
  parameter int N_SECT = 4800,
  parameter int DA_W   = 13
) (
  input  logic [DA_W-1:0] da_i,
  output logic [DA_W-1:0] da_nxt_o,
  output logic            wrap_o
);
  localparam logic [DA_W-1:0] LAST = DA_W'(N_SECT - 1);

  always_comb begin
    wrap_o   = (da_i == LAST);
    da_nxt_o = wrap_o ? '0 : da_i + DA_W'(1);
  end
endmodule

// File: rtl/dsq_drive.sv
module dsq_drive (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_sinc_i,
  input  logic clr_sinc_i,
  input  logic set_wlv_i,
  input  logic clr_wlv_i,
  output logic rdy_o,
  output logic wlv_o
);
  logic sinc_q, wlv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sinc_q <= 1'b0;
      wlv_q  <= 1'b0;
    end else begin
      if (clr_sinc_i) sinc_q <= 1'b0;
      else if (set_sinc_i) sinc_q <= 1'b1;
      if (clr_wlv_i) wlv_q <= 1'b0;
      else if (set_wlv_i) wlv_q <= 1'b1;
    end
  end

  assign rdy_o = !sinc_q;
  assign wlv_o = wlv_q;
endmodule

// File: rtl/disk_seq.sv
module disk_seq
  import dsq_pkg::*;
#(
  parameter int N_UNITS  = 4,
  parameter int N_SECT   = 4800,
  parameter int SEEK_DLY = 10,
  parameter int BA_W     = 22,
  parameter int UW       = (N_UNITS > 1) ? $clog2(N_UNITS) : 1,
  parameter int DA_W     = (N_SECT > 1) ? $clog2(N_SECT) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_sel_i,
  input  logic [31:0]        wr_data_i,
  input  logic [N_UNITS-1:0] wlock_i,
  input  logic               seek_fail_i,
  input  logic               sector_done_i,
  input  logic               nxm_i,
  output logic               irq_o,
  output logic               done_o,
  output logic               ie_o,
  output logic               busy_o,
  output logic [2:0]         func_o,
  output logic [UW-1:0]      unit_o,
  output logic               err_nxm_o,
  output logic               err_ovf_o,
  output logic               err_wlv_o,
  output logic               err_nrdy_o,
  output logic [DA_W-1:0]    da_o,
  output logic [BA_W-1:0]    ba_o,
  output logic               xfer_req_o,
  output logic               xfer_write_o,
  output logic [N_UNITS-1:0] drv_rdy_o,
  output logic [N_UNITS-1:0] drv_wlv_o
);
  state_e          state_q;
  func_e           func_q;
  logic [UW-1:0]   unit_q;
  logic            ie_q, done_q;
  logic            e_nxm_q, e_ovf_q, e_wlv_q, e_nrdy_q;
  logic [DA_W-1:0] da_q, da_nxt;
  logic [BA_W-1:0] ba_q;
  logic            wrap, tmr_fin_raw;
  logic [N_UNITS-1:0] rdy;
  logic            unused_wr;

  // decode of the host write
  logic    csr_wr, go, rst_cmd, idle, cmd, u_rdy, u_lock;
  logic    start_dly, start_xfer, rej_nrdy, rej_wl, tmr_fin, sec_end;
  func_e   wf;
  logic [UW-1:0] wu;

  always_comb begin
    csr_wr  = wr_en_i && (wr_sel_i == SEL_CSR);
    go      = csr_wr && wr_data_i[CSR_GO];
    wf      = func_e'(wr_data_i[CSR_FN +: 3]);
    wu      = wr_data_i[CSR_UNIT +: UW];
    idle    = (state_q == ST_IDLE);
    rst_cmd = go && (wf == FN_RESET);
    cmd     = go && idle;
    u_rdy   = rdy[wu];
    u_lock  = wlock_i[wu];
    start_dly  = cmd && ((wf == FN_HOME) || (wf == FN_SEEK && u_rdy));
    start_xfer = cmd && u_rdy && ((wf == FN_READ) || (wf == FN_WRITE && !u_lock));
    rej_nrdy   = cmd && !u_rdy && (wf == FN_SEEK || wf == FN_READ || wf == FN_WRITE);
    rej_wl     = cmd && u_rdy && (wf == FN_WRITE) && u_lock;
    tmr_fin    = tmr_fin_raw && !rst_cmd;
    sec_end    = (state_q == ST_XFER) && sector_done_i && !rst_cmd;
  end

  dsq_timer #(.DLY(SEEK_DLY)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_dly),
    .run_i   (state_q == ST_WAIT),
    .fin_o   (tmr_fin_raw)
  );

  dsq_addr #(.N_SECT(N_SECT), .DA_W(DA_W)) u_addr (
    .da_i     (da_q),
    .da_nxt_o (da_nxt),
    .wrap_o   (wrap)
  );

  for (genvar u = 0; u < N_UNITS; u++) begin : g_drv
    dsq_drive u_drv (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .set_sinc_i (tmr_fin && func_q == FN_SEEK && seek_fail_i && unit_q == UW'(u)),
      .clr_sinc_i (tmr_fin && func_q == FN_HOME && unit_q == UW'(u)),
      .set_wlv_i  (rej_wl && wu == UW'(u)),
      .clr_wlv_i  (rst_cmd),
      .rdy_o      (rdy[u]),
      .wlv_o      (drv_wlv_o[u])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      func_q   <= FN_RESET;
      unit_q   <= '0;
      ie_q     <= 1'b0;
      done_q   <= 1'b1;
      e_nxm_q  <= 1'b0;
      e_ovf_q  <= 1'b0;
      e_wlv_q  <= 1'b0;
      e_nrdy_q <= 1'b0;
    end else begin
      if (csr_wr && (idle || rst_cmd)) begin
        ie_q   <= wr_data_i[CSR_IE];
        func_q <= wf;
        unit_q <= wu;
      end
      if (rst_cmd || start_dly || start_xfer || rej_nrdy || rej_wl) begin
        {e_nxm_q, e_ovf_q, e_wlv_q, e_nrdy_q} <= '0;
      end
      if (rst_cmd) begin
        state_q <= ST_IDLE;
        done_q  <= 1'b1;
      end else if (start_dly) begin
        state_q <= ST_WAIT;
        done_q  <= 1'b0;
      end else if (start_xfer) begin
        state_q <= ST_XFER;
        done_q  <= 1'b0;
      end else if (rej_nrdy) begin
        e_nrdy_q <= 1'b1;
      end else if (rej_wl) begin
        e_wlv_q <= 1'b1;
      end else if (tmr_fin) begin
        state_q <= ST_IDLE;
        done_q  <= 1'b1;
      end else if (sec_end) begin
        state_q <= ST_IDLE;
        done_q  <= 1'b1;
        e_nxm_q <= nxm_i;
        e_ovf_q <= wrap;
      end
    end
  end

  // sector address advances on every started sector, failed or not
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) da_q <= '0;
    else if (sec_end) da_q <= da_nxt;
    else if (wr_en_i && wr_sel_i == SEL_DA && idle) da_q <= wr_data_i[DA_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ba_q <= '0;
    else if (wr_en_i && wr_sel_i == SEL_BA) ba_q <= wr_data_i[BA_W-1:0];
  end

  assign unused_wr    = ^wr_data_i;
  assign irq_o        = ie_q && done_q;
  assign done_o       = done_q;
  assign ie_o         = ie_q;
  assign busy_o       = !idle;
  assign func_o       = func_q;
  assign unit_o       = unit_q;
  assign err_nxm_o    = e_nxm_q;
  assign err_ovf_o    = e_ovf_q;
  assign err_wlv_o    = e_wlv_q;
  assign err_nrdy_o   = e_nrdy_q;
  assign da_o         = da_q;
  assign ba_o         = ba_q;
  assign xfer_req_o   = (state_q == ST_XFER);
  assign xfer_write_o = (func_q == FN_WRITE);
  assign drv_rdy_o    = rdy;
endmodule

// File: rtl/dsq_chk.sv
module dsq_chk #(
  parameter int N_UNITS = 4,
  parameter int BA_W    = 22,
  parameter int UW      = 2,
  parameter int DA_W    = 13
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [1:0]         wr_sel_i,
  input logic [31:0]        wr_data_i,
  input logic [N_UNITS-1:0] wlock_i,
  input logic               sector_done_i,
  input logic               done_o,
  input logic               ie_o,
  input logic               busy_o,
  input logic [DA_W-1:0]    da_o,
  input logic [BA_W-1:0]    ba_o,
  input logic               xfer_req_o
);
  logic go, go_rst, go_home, go_wl;
  logic [4:0] wait_cnt;

  always_comb begin
    go      = wr_en_i && wr_sel_i == 2'd0 && wr_data_i[0];
    go_rst  = go && wr_data_i[3:1] == 3'd0;
    go_home = go && !busy_o && wr_data_i[3:1] == 3'd4;
    go_wl   = go && !busy_o && wr_data_i[3:1] == 3'd1 && wlock_i[wr_data_i[8 +: UW]];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wait_cnt <= '0;
    else if (busy_o && !xfer_req_o) wait_cnt <= (wait_cnt == 5'd31) ? wait_cnt : wait_cnt + 5'd1;
    else wait_cnt <= '0;
  end

  AST_RST_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_rst |=> done_o && !busy_o && !xfer_req_o); // R1
  AST_RST_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_rst |=> ie_o == $past(wr_data_i[6])); // R1
  AST_HOME_LATE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_home |=> !done_o && busy_o); // R4
  AST_WAIT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_cnt < 5'd25); // R5
  AST_DA_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o && sector_done_i && !go_rst |=> da_o != $past(da_o)); // R7
  AST_WL_NO_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_wl |=> !xfer_req_o && $stable(da_o)); // R12
  AST_BA_LOW_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_sel_i == 2'd2 |=> ba_o == $past(wr_data_i[BA_W-1:0])); // R13
endmodule

bind disk_seq dsq_chk #(
  .N_UNITS(N_UNITS), .BA_W(BA_W), .UW(UW), .DA_W(DA_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
  .wr_data_i(wr_data_i), .wlock_i(wlock_i), .sector_done_i(sector_done_i),
  .done_o(done_o), .ie_o(ie_o), .busy_o(busy_o), .da_o(da_o), .ba_o(ba_o),
  .xfer_req_o(xfer_req_o)
);

// File: tb/disk_seq_tb.sv
module disk_seq_tb;
  localparam int CLK_P   = 10;
  localparam int NU      = 4;
  localparam int NS      = 4800;
  localparam int DLY     = 10;
  localparam int UW      = 2;
  localparam int DA_W    = 13;
  localparam int BA_W    = 22;
  localparam int F_RESET = 0, F_WRITE = 1, F_READ = 2, F_SEEK = 3, F_HOME = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [NU-1:0] wlock = '0;
  logic seek_fail = 1'b0, sdone = 1'b0, nxm = 1'b0;
  logic irq, done, ie, busy, e_nxm, e_ovf, e_wlv, e_nrdy, xreq, xwr;
  logic [2:0] func;
  logic [UW-1:0] unit;
  logic [DA_W-1:0] da;
  logic [BA_W-1:0] ba;
  logic [NU-1:0] rdy, wlv;
  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  disk_seq #(.N_UNITS(NU), .N_SECT(NS), .SEEK_DLY(DLY), .BA_W(BA_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .wlock_i(wlock), .seek_fail_i(seek_fail), .sector_done_i(sdone), .nxm_i(nxm),
    .irq_o(irq), .done_o(done), .ie_o(ie), .busy_o(busy), .func_o(func), .unit_o(unit),
    .err_nxm_o(e_nxm), .err_ovf_o(e_ovf), .err_wlv_o(e_wlv), .err_nrdy_o(e_nrdy),
    .da_o(da), .ba_o(ba), .xfer_req_o(xreq), .xfer_write_o(xwr),
    .drv_rdy_o(rdy), .drv_wlv_o(wlv)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cw(input int go, input int fn, input int ien, input int un);
    return 32'((un << 8) | (ien << 6) | (fn << 1) | go);
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic sector(input logic fault);
    @(negedge clk);
    sdone = 1'b1; nxm = fault;
    @(negedge clk);
    sdone = 1'b0; nxm = 1'b0;
  endtask

  task automatic t_reset_state;
    chk("R2 reset done", done, 1);
    chk("R2 reset ie", ie, 0);
    chk("R2 reset irq", irq, 0);
    chk("R1 reset busy", busy, 0);
    chk("R9 reset ready", rdy, 4'hF);
  endtask

  task automatic t_ie_only;
    wr(0, cw(0, F_SEEK, 1, 1));
    chk("R3 no start", busy, 0);
    chk("R3 func load", func, F_SEEK);
    chk("R3 unit load", unit, 1);
    chk("R2 irq on ie", irq, 1);
    wr(0, cw(0, F_READ, 0, 0));
    chk("R2 irq off", irq, 0);
  endtask

  task automatic t_seek_delay;
    wr(0, cw(1, F_SEEK, 1, 0));
    chk("R4 done low", done, 0);
    chk("R2 irq low", irq, 0);
    repeat (DLY - 1) @(negedge clk);
    chk("R4 still waiting", done, 0);
    @(negedge clk);
    chk("R4 done at delay", done, 1);
    chk("R5 delay under 25", (DLY < 25), 1);
    chk("R2 irq after seek", irq, 1);
    chk("R9 good seek ready", rdy[0], 1);
  endtask

  task automatic t_read;
    wr(1, 32'd100);
    wr(0, cw(1, F_READ, 0, 0));
    chk("R6 xfer req", xreq, 1);
    chk("R6 read dir", xwr, 0);
    chk("R6 done low", done, 0);
    repeat (3) @(negedge clk);
    chk("R6 waits stub", xreq, 1);
    sector(1'b0);
    chk("R6 done", done, 1);
    chk("R6 da advance", da, 101);
    chk("R6 no nxm", e_nxm, 0);
  endtask

  task automatic t_busy_ignore;
    wr(0, cw(1, F_READ, 1, 0));
    wr(0, cw(0, F_SEEK, 0, 2));
    chk("R3 busy ie kept", ie, 1);
    chk("R3 busy func kept", func, F_READ);
    wr(1, 32'd7);
    chk("R13 da write busy ignored", da, 101);
    sector(1'b0);
    chk("R6 second sector", da, 102);
  endtask

  task automatic t_nxm;
    wr(1, 32'd5);
    wr(0, cw(1, F_WRITE, 0, 2));
    chk("R6 write dir", xwr, 1);
    sector(1'b1);
    chk("R7 nxm flag", e_nxm, 1);
    chk("R7 da still advances", da, 6);
    chk("R7 done", done, 1);
  endtask

  task automatic t_ovf;
    wr(1, 32'(NS - 1));
    wr(0, cw(1, F_READ, 0, 0));
    chk("R7 nxm cleared at start", e_nxm, 0);
    sector(1'b0);
    chk("R8 wrap", da, 0);
    chk("R8 ovf flag", e_ovf, 1);
  endtask

  task automatic t_reset_busy;
    wr(1, 32'd40);
    wr(0, cw(1, F_READ, 0, 0));
    chk("R1 busy before", busy, 1);
    wr(0, cw(1, F_RESET, 1, 0));
    chk("R1 done", done, 1);
    chk("R1 idle", busy, 0);
    chk("R1 req dropped", xreq, 0);
    chk("R1 ie kept", ie, 1);
    chk("R1 irq", irq, 1);
    chk("R1 errs clear", {e_nxm, e_ovf, e_wlv, e_nrdy}, 0);
    sector(1'b0);
    chk("R1 late stub ignored", da, 40);
  endtask

  task automatic t_seek_fail;
    seek_fail = 1'b1;
    wr(0, cw(1, F_SEEK, 0, 1));
    repeat (DLY) @(negedge clk);
    seek_fail = 1'b0;
    chk("R9 unit1 not ready", rdy[1], 0);
    chk("R11 others ready", {rdy[3:2], rdy[0]}, 3'b111);
    wr(0, cw(1, F_READ, 0, 1));
    chk("R9 refused nrdy", e_nrdy, 1);
    chk("R9 no xfer", xreq, 0);
    chk("R9 done stays", done, 1);
    chk("R9 da unchanged", da, 40);
    wr(0, cw(1, F_SEEK, 0, 1));
    chk("R9 seek refused", busy, 0);
  endtask

  task automatic t_home;
    wr(0, cw(1, F_HOME, 0, 1));
    chk("R10 home runs", busy, 1);
    chk("R10 home done low", done, 0);
    repeat (DLY) @(negedge clk);
    chk("R10 home done", done, 1);
    chk("R10 ready again", rdy[1], 1);
  endtask

  task automatic t_wlock;
    wlock = 4'b1000;
    wr(0, cw(1, F_WRITE, 0, 3));
    chk("R12 no xfer", xreq, 0);
    chk("R12 err wlv", e_wlv, 1);
    chk("R12 unit3 flag", wlv[3], 1);
    chk("R11 others clean", wlv[2:0], 0);
    chk("R12 da unchanged", da, 40);
    wr(0, cw(1, F_READ, 0, 3));
    chk("R12 flag sticky", wlv[3], 1);
    sector(1'b0);
    wr(0, cw(1, F_RESET, 0, 0));
    chk("R12 reset clears", wlv, 0);
    wlock = '0;
  endtask

  task automatic t_ba;
    wr(2, 32'h010000C8);
    chk("R13 high bits dropped", ba, 22'h0000C8);
    wr(2, 32'hFFC01234);
    chk("R13 mask", ba, 22'h001234);
    chk("R13 no error", {e_nxm, e_ovf, e_wlv, e_nrdy}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_ie_only();
    t_seek_delay();
    t_read();
    t_busy_ignore();
    t_nxm();
    t_ovf();
    t_reset_busy();
    t_seek_fail();
    t_home();
    t_wlock();
    t_ba();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule